// File: doc/BRIEF.md
# OSD Horizontal Character Timing

This block generates the pixel-rate horizontal timing for an on-screen display laid out as a row of 30 character cells, each 12 dots wide. It watches the horizontal sync input. After each rising sync edge it waits a programmable number of pixel clocks. It then opens a display window and reports, for every pixel clock, which character column and which dot within that character is being drawn. A font and colour stage downstream uses these indices to fetch glyph bits.

Software sets three things. The position value moves the window right in steps of six pixels from a fixed minimum offset. The resolution value gives the line length in character cells, which limits how many columns can be shown. The double-width flag stretches every dot to two pixel clocks. In double-width mode only the even columns carry visible characters, and the odd columns are flagged as hidden. A new sync edge always restarts the timing, even in the middle of a line.

Top module: `osd_htiming`

## Requirements
- R1: While `rst_ni` is low, and until the first sync edge after it, `hde_o` and `hide_o` are 0 and `col_o` and `dot_o` are 0.
- R2: A sync edge is the first clock edge at which `hsync_i` is sampled high after being sampled low. `hde_o` goes high exactly `hpos_i*6+49` clock cycles after that edge.
- R3: While `hde_o` is high in single-width mode, `dot_o` steps through 0 to 11 one value per clock, and wraps to 0 after 11.
- R4: `col_o` is 0 at the start of the window and increments each time `dot_o` wraps. With `hres_i >= 30`, the window closes after dot 11 of column 29, so it is 360 dots long.
- R5: With `dbl_wide_i` = 1, each dot value is held for two clocks. A full 30-column window therefore lasts 720 clocks.
- R6: `hide_o` is 1 exactly when `hde_o` is high, `dbl_wide_i` = 1 and `col_o` is odd.
- R7: A sync edge during the delay or during the window drives `hde_o` low on the next cycle and restarts the delay from that edge.
- R8: With `hres_i` below 30, only columns 0 to `hres_i-1` are shown, so the window is `hres_i*12` dots long. With `hres_i` = 0, `hde_o` stays low for the whole line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync; the rising edge starts a line |
| hpos_i | input | HPOS_W | Horizontal position; delay = value*6+49 clocks |
| hres_i | input | RES_W | Line length in character cells |
| dbl_wide_i | input | 1 | Double-width mode |
| hde_o | output | 1 | Horizontal display enable |
| col_o | output | $clog2(COLS) | Character column index |
| dot_o | output | $clog2(CHAR_DOTS) | Dot index within the character |
| hide_o | output | 1 | Current column is hidden (odd column in double width) |

## Verification
A wrong delay count moves the rising edge of `hde_o` away from `hpos_i*6+49` clocks. This shows up at the very first enabled pixel of the line. A stuck or miscounting dot or column counter puts a wrong `dot_o` or `col_o` value on the output within one character cell. It also moves the falling edge of `hde_o` at the end of the window. A lost double-width phase or a missed restart shows within one or two clocks as a wrong dot hold, a wrong `hide_o`, or an enable that stays high after a new sync edge.

// File: rtl/osd_htiming_pkg.sv
package osd_htiming_pkg;
  localparam int unsigned OSD_COLS  = 30;
  localparam int unsigned CHAR_DOTS = 12;
  localparam int unsigned HPOS_MUL  = 6;
  localparam int unsigned HPOS_OFS  = 49;
endpackage

// File: rtl/osd_hsync_edge.sv
module osd_hsync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic rise_o
);
  logic sync_q;

  // reset high so a sync held high through reset gives no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b1;
    else         sync_q <= hsync_i;
  end

  assign rise_o = hsync_i & ~sync_q;
endmodule

// File: rtl/osd_hdelay.sv
module osd_hdelay #(
  parameter int unsigned HPOS_W = 8,
  parameter int unsigned MUL    = 6,
  parameter int unsigned OFS    = 49
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [HPOS_W-1:0] hpos_i,
  output logic              start_o
);
  localparam int unsigned MAX_DLY = (2**HPOS_W - 1) * MUL + OFS;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt_q, target, last;
  logic             busy_q, hit;

  assign target = CNT_W'(hpos_i) * CNT_W'(MUL) + CNT_W'(OFS);
  assign last   = target - 1'b1;
  assign hit    = busy_q && (cnt_q == last);
  assign start_o = hit && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (hit) busy_q <= 1'b0;
      else     cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_start_after_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !busy_q);
  assert_restart_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/osd_hchar_cnt.sv
module osd_hchar_cnt #(
  parameter int unsigned COLS      = 30,
  parameter int unsigned CHAR_DOTS = 12,
  parameter int unsigned RES_W     = 8,
  localparam int unsigned COL_W    = $clog2(COLS),
  localparam int unsigned DOT_W    = $clog2(CHAR_DOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic [RES_W-1:0] hres_i,
  input  logic             dbl_i,
  output logic             active_o,
  output logic [COL_W-1:0] col_o,
  output logic [DOT_W-1:0] dot_o,
  output logic             hide_o
);
  logic             active_q, half_q;
  logic [COL_W-1:0] col_q, last_col;
  logic [DOT_W-1:0] dot_q;
  logic             has_cols, end_dot, step, end_col;

  assign has_cols = (hres_i != '0);
  assign last_col = (hres_i >= RES_W'(COLS)) ? COL_W'(COLS - 1)
                                              : COL_W'(hres_i - 1'b1);
  assign end_dot  = (dot_q == DOT_W'(CHAR_DOTS - 1));
  assign end_col  = (col_q == last_col);
  assign step     = active_q && (!dbl_i || half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (restart_i) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (start_i) begin
      active_q <= has_cols;
      half_q   <= 1'b0;
      col_q    <= '0;
      dot_q    <= '0;
    end else if (active_q) begin
      if (!step) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        if (end_dot) begin
          dot_q <= '0;
          if (end_col) begin
            active_q <= 1'b0;
            col_q    <= '0;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end else begin
          dot_q <= dot_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign col_o    = col_q;
  assign dot_o    = dot_q;
  assign hide_o   = active_q & dbl_i & col_q[0];

  assert_dot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (dot_q < DOT_W'(CHAR_DOTS)));
  assert_col_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (col_q <= last_col));
  assert_dbl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && dbl_i && !half_q && !restart_i && !start_i)
      |=> ($stable(dot_q) && $stable(col_q) && active_q));
  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && end_dot && !end_col && !restart_i && !start_i)
      |=> (col_q == $past(col_q) + 1'b1 && dot_q == '0 && active_q));
endmodule

// File: rtl/osd_htiming.sv
module osd_htiming
  import osd_htiming_pkg::*;
#(
  parameter int unsigned HPOS_W    = 8,
  parameter int unsigned RES_W     = 8,
  parameter int unsigned COLS      = OSD_COLS,
  parameter int unsigned CHAR_DOTS = osd_htiming_pkg::CHAR_DOTS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hsync_i,
  input  logic [HPOS_W-1:0]            hpos_i,
  input  logic [RES_W-1:0]             hres_i,
  input  logic                         dbl_wide_i,
  output logic                         hde_o,
  output logic [$clog2(COLS)-1:0]      col_o,
  output logic [$clog2(CHAR_DOTS)-1:0] dot_o,
  output logic                         hide_o
);
  logic rise, start;

  osd_hsync_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_i (hsync_i),
    .rise_o  (rise)
  );

  osd_hdelay #(
    .HPOS_W (HPOS_W),
    .MUL    (HPOS_MUL),
    .OFS    (HPOS_OFS)
  ) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rise),
    .hpos_i    (hpos_i),
    .start_o   (start)
  );

  osd_hchar_cnt #(
    .COLS      (COLS),
    .CHAR_DOTS (CHAR_DOTS),
    .RES_W     (RES_W)
  ) u_char (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rise),
    .start_i   (start),
    .hres_i    (hres_i),
    .dbl_i     (dbl_wide_i),
    .active_o  (hde_o),
    .col_o     (col_o),
    .dot_o     (dot_o),
    .hide_o    (hide_o)
  );

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !hde_o);
  assert_hide_odd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hide_o |-> (hde_o && col_o[0] && dbl_wide_i));
  assert_open_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hde_o) |-> (col_o == '0 && dot_o == '0));
endmodule

// File: tb/tb_osd_htiming.sv
module tb_osd_htiming;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_i = 1'b0;
  logic [7:0] hpos_i = '0;
  logic [7:0] hres_i = 8'd30;
  logic       dbl_wide_i = 1'b0;
  logic       hde_o, hide_o;
  logic [4:0] col_o;
  logic [3:0] dot_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  osd_htiming dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .hpos_i(hpos_i),
    .hres_i(hres_i), .dbl_wide_i(dbl_wide_i), .hde_o(hde_o), .col_o(col_o),
    .dot_o(dot_o), .hide_o(hide_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge; raises sync and follows the line (aborts after abort_n if > 0)
  task automatic run_line(input int hp, input int dbl, input int hr, input int abort_n,
                          input bit after_restart);
    int d, nc, w, last_n;
    d  = hp * 6 + 49;
    nc = (hr >= 30) ? 30 : hr;
    w  = nc * 12 * (dbl ? 2 : 1);
    last_n = d + w + 4;
    hpos_i = 8'(hp);
    hres_i = 8'(hr);
    dbl_wide_i = dbl[0];
    hsync_i = 1'b1;
    for (int n = 0; n <= last_n; n++) begin
      int p, pp, e_de, e_col, e_dot, e_hide;
      string tde;
      @(posedge clk_i);
      @(negedge clk_i);
      if (n == 3) hsync_i = 1'b0;
      e_de = (n >= d && n < d + w) ? 1 : 0;
      if (after_restart && n <= 1) tde = "R7";
      else if (n <= d) tde = "R2";
      else if (hr < 30) tde = "R8";
      else if (dbl != 0) tde = "R5";
      else tde = "R4";
      check(tde, "hde_o", int'(hde_o), e_de);
      if (e_de != 0) begin
        p  = n - d;
        pp = dbl ? p / 2 : p;
        e_col = pp / 12;
        e_dot = pp % 12;
        e_hide = (dbl != 0 && (e_col % 2) == 1) ? 1 : 0;
        check(dbl ? "R5" : "R3", "dot_o", int'(dot_o), e_dot);
        check("R4", "col_o", int'(col_o), e_col);
        check("R6", "hide_o", int'(hide_o), e_hide);
      end else begin
        check("R6", "hide_o idle", int'(hide_o), 0);
      end
      if (abort_n > 0 && n == abort_n) return;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "hde_o in reset", int'(hde_o), 0);
    check("R1", "hide_o in reset", int'(hide_o), 0);
    check("R1", "col_o in reset", int'(col_o), 0);
    check("R1", "dot_o in reset", int'(dot_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1", "hde_o after reset", int'(hde_o), 0);

    run_line(0,   0, 30,  0, 1'b0);
    run_line(1,   0, 40,  0, 1'b0);
    run_line(0,   1, 30,  0, 1'b0);
    run_line(5,   1, 31,  0, 1'b0);
    run_line(255, 0, 30,  0, 1'b0);
    run_line(255, 1, 255, 0, 1'b0);
    run_line(2,   0, 10,  0, 1'b0);   // R8 short line
    run_line(0,   0, 29,  0, 1'b0);
    run_line(7,   1, 1,   0, 1'b0);
    run_line(4,   0, 0,   0, 1'b0);   // R8 no columns
    // R7: restart inside the window, then inside the delay
    run_line(0,   0, 30, 100, 1'b0);
    run_line(3,   1, 30,  0, 1'b1);
    run_line(10,  0, 30, 20, 1'b0);
    run_line(0,   0, 30,  0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule